// File: doc/BRIEF.md
# Serial Lane Frame Alignment Detector

This block watches a single bit-serial lane that a 1:4 bit de-interleaver produces, and hunts for the 32-bit overhead marker made of two A1 bytes followed by two A2 bytes. While it hunts, a timer runs. If the timer runs out before any marker arrives, the block sends a one-cycle rotate request to the de-interleaver so that a different lane is presented, and the hunt starts again.

The first marker it finds anchors a frame position counter. A second marker exactly one frame later declares lock and raises the in-frame flag. While locked, only the expected frame slot is examined. Four misses in a row drop lock. A hit after three or fewer misses clears the miss run. The frame length in bits and the hunt timeout in lane clocks are parameters. A synchronous active-low frame reset returns the block to hunting with the flag low.

Top module: `frame_align_det`

## Requirements
- R1: The marker is the 32-bit value 0xF6F62828, with the oldest bit first. The window tested at each clock is the 31 previously sampled bits followed by the bit on `lane_bit` in that cycle. A window that differs from the marker in any bit is not a marker.
- R2: A clock edge with `frame_rst_n` low puts the block in the hunt state with a cleared window, timer and miss count. From the next cycle on, `in_frame` and `roll_pulse` are both 0.
- R3: In the hunt state, when TIMEOUT_CLKS consecutive clocks pass with no marker, `roll_pulse` is 1 for exactly one cycle and the timer restarts. Rolls therefore repeat every TIMEOUT_CLKS clocks while nothing is found.
- R4: A marker in the hunt state moves the block to verification and resets the frame position. The expected slot is the clock exactly FRAME_BITS clocks after the one that completed the marker.
- R5: A marker at the expected slot during verification raises `in_frame` from the next cycle on.
- R6: A missing marker at the expected slot during verification returns the block to hunting with a fresh timer. `in_frame` stays 0.
- R7: While locked, markers that complete at any clock other than the expected slot are ignored.
- R8: While locked, four consecutive slot misses clear `in_frame` after the fourth. A slot hit after one to three misses clears the miss run, so a later loss again needs four new misses.
- R9: `roll_pulse` is never 1 outside the hunt state, and is never 1 while `in_frame` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, one bit per cycle |
| frame_rst_n | input | 1 | Synchronous active-low frame reset |
| lane_bit | input | 1 | Serial data bit of the monitored lane |
| roll_pulse | output | 1 | One-cycle request to rotate the de-interleaver lanes |
| in_frame | output | 1 | High when locked, low while hunting or verifying |

## Verification
A wrong frame position or miss count shows up as a lock gained or dropped one frame slot early or late. That is visible on `in_frame` within one frame of the fault. A wrong hunt timer or a spurious marker match shows up as `roll_pulse` moving off its TIMEOUT_CLKS grid, and that appears by the next expected roll at the latest. The bench compares both outputs with its own cycle model on every clock, so any such drift is caught in the cycle where it first reaches a port.

// File: rtl/fad_pkg.sv
// Shared types and constants for the frame alignment detector.
package fad_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } fad_state_e;

    localparam int          MARKER_BITS = 32;
    localparam logic [31:0] MARKER      = 32'hF6F6_2828;
endpackage

// File: rtl/fad_window.sv
// Sliding marker window. Holds the last MARKER_BITS-1 lane bits and
// compares them, together with the current bit, against the marker.
// Assumes one lane bit per clock, oldest bit in the MSB position.
module fad_window
    import fad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit
);
    logic [MARKER_BITS-2:0] hist_q;

    // Shift in one lane bit per clock; cleared by frame reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[MARKER_BITS-3:0], bit_in};
    end

    // Marker compare over history plus the bit of this cycle.
    always_comb hit = ({hist_q, bit_in} == MARKER);
endmodule

// File: rtl/fad_slot_counter.sv
// Frame position counter. Restart sets position zero; at_slot marks the
// clock FRAME_BITS clocks after a restart and every frame after that.
// Assumes FRAME_BITS >= 2.
module fad_slot_counter #(
    parameter int FRAME_BITS = 77760
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic at_slot
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    logic [CW-1:0] pos_q;

    // Advance the position modulo the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pos_q <= '0;
        else if (pos_q == LAST) pos_q <= '0;
        else                    pos_q <= pos_q + 1'b1;
    end

    // Expected-slot strobe.
    always_comb at_slot = (pos_q == LAST);

    // R4: the clock after a restart is never a slot check.
    assert_slot_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !at_slot);
endmodule

// File: rtl/fad_hunt_timer.sv
// Hunt timeout counter. Counts while run is high and fires expire on the
// TIMEOUT_CLKS-th consecutive running clock, then restarts. Dropping run
// clears it. Assumes TIMEOUT_CLKS >= 2.
module fad_hunt_timer #(
    parameter int TIMEOUT_CLKS = 155520
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(TIMEOUT_CLKS);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CLKS - 1);

    logic [TW-1:0] cnt_q;

    // Expiry when the count reaches its last value while running.
    always_comb expire = run && (cnt_q == LAST);

    // Count running clocks; restart on expiry or when halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    // R3: the count never passes the timeout.
    assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/frame_align_det.sv
// Frame alignment detector for one de-interleaved serial lane. Hunts for
// the A1A1A2A2 marker, requests a lane roll on hunt timeout, confirms
// with a second marker one frame later and drops lock after four
// consecutive slot misses. Assumes one bit per clock and a synchronous
// active-low frame reset.
module frame_align_det
    import fad_pkg::*;
#(
    parameter int FRAME_BITS   = 77760,
    parameter int TIMEOUT_CLKS = 155520
) (
    input  logic clk,
    input  logic frame_rst_n,
    input  logic lane_bit,
    output logic roll_pulse,
    output logic in_frame
);
    localparam int MISS_LIMIT = 4;
    localparam int MW = $clog2(MISS_LIMIT);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

    fad_state_e    state_q, state_d;
    logic [MW-1:0] miss_q, miss_d;
    logic          hit, slot_now, expire, roll_q;
    logic          anchor, hunting;

    fad_window u_window (
        .clk    (clk),
        .rst_n  (frame_rst_n),
        .bit_in (lane_bit),
        .hit    (hit)
    );

    // Anchor the frame position on a marker found while hunting.
    always_comb begin
        hunting = (state_q == ST_HUNT);
        anchor  = hunting && hit;
    end

    fad_slot_counter #(.FRAME_BITS(FRAME_BITS)) u_slot (
        .clk     (clk),
        .rst_n   (frame_rst_n),
        .restart (anchor),
        .at_slot (slot_now)
    );

    fad_hunt_timer #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (frame_rst_n),
        .run    (hunting && !hit),
        .expire (expire)
    );

    // Next state and miss run from the marker result at the slot.
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        unique case (state_q)
            ST_HUNT: begin
                miss_d = '0;
                if (hit) state_d = ST_VERIFY;
            end
            ST_VERIFY: begin
                miss_d = '0;
                if (slot_now) state_d = hit ? ST_LOCKED : ST_HUNT;
            end
            ST_LOCKED: begin
                if (slot_now) begin
                    if (hit) begin
                        miss_d = '0;
                    end else if (miss_q == MISS_LAST) begin
                        miss_d  = '0;
                        state_d = ST_HUNT;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
            end
            default: begin
                miss_d  = '0;
                state_d = ST_HUNT;
            end
        endcase
    end

    // State, miss run and registered roll request.
    always_ff @(posedge clk) begin
        if (!frame_rst_n) begin
            state_q <= ST_HUNT;
            miss_q  <= '0;
            roll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
            roll_q  <= expire;
        end
    end

    // Output drive.
    always_comb begin
        roll_pulse = roll_q;
        in_frame   = (state_q == ST_LOCKED);
    end

    // R3: a roll request lasts one cycle.
    assert_roll_single_R3: assert property (@(posedge clk) disable iff (!frame_rst_n)
        roll_pulse |=> !roll_pulse);

    // R9: a roll request only while hunting and never with the flag high.
    assert_roll_hunting_R9: assert property (@(posedge clk) disable iff (!frame_rst_n)
        roll_pulse |-> (state_q == ST_HUNT) && !in_frame);

    // R5: lock is only gained from verification on a slot hit.
    assert_lock_entry_R5: assert property (@(posedge clk) disable iff (!frame_rst_n)
        $rose(in_frame) |-> ($past(state_q) == ST_VERIFY) && $past(slot_now) && $past(hit));

    // R8: lock is only lost after three earlier misses and a fourth at the slot.
    assert_lock_exit_R8: assert property (@(posedge clk) disable iff (!frame_rst_n)
        $fell(in_frame) && $past(frame_rst_n) |-> ($past(miss_q) == MISS_LAST) && $past(slot_now));
endmodule

// File: tb/tb_frame_align_det.sv
// Bench: drives bits at the falling edge, advances an independent cycle
// model at each rising edge and compares both outputs at the next falling edge.
module tb_frame_align_det;
    localparam int FB  = 64;
    localparam int TO  = 200;
    localparam logic [31:0] MK = 32'hF6F62828;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic frame_rst_n = 1'b0;
    logic lane_bit = 1'b0;
    logic roll_pulse, in_frame;

    int checks = 0, fails = 0, cycles = 0, rolls = 0;
    bit done = 1'b0;

    // model state: 0 hunt, 1 verify, 2 locked
    int m_st = 0, m_pos = 0, m_cnt = 0, m_miss = 0;
    bit m_roll = 1'b0;
    logic [31:0] m_hist = '0;

    frame_align_det #(.FRAME_BITS(FB), .TIMEOUT_CLKS(TO)) dut (
        .clk(clk), .frame_rst_n(frame_rst_n), .lane_bit(lane_bit),
        .roll_pulse(roll_pulse), .in_frame(in_frame)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles++;

    initial begin
        wait (cycles >= LIMIT);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic bit slot_hit_next(input int pos);
        return pos == FB - 1;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    // Advance the model for one clock with the given inputs.
    task automatic model_edge(input bit b, input bit r);
        bit m, slot;
        if (!r) begin
            m_st = 0; m_cnt = 0; m_miss = 0; m_hist = '0; m_roll = 0; m_pos = 0;
            return;
        end
        m_hist = {m_hist[30:0], b};
        m = (m_hist == MK);
        slot = slot_hit_next(m_pos);
        m_roll = 0;
        if (m_st == 0 && m) m_pos = 0;
        else m_pos = slot ? 0 : m_pos + 1;
        case (m_st)
            0: begin
                if (m) begin m_st = 1; m_cnt = 0; end
                else if (m_cnt == TO - 1) begin m_roll = 1; m_cnt = 0; end
                else m_cnt++;
            end
            1: if (slot) begin m_st = m ? 2 : 0; m_cnt = 0; end
            default: if (slot) begin
                if (m) m_miss = 0;
                else if (m_miss == 3) begin m_miss = 0; m_st = 0; m_cnt = 0; end
                else m_miss++;
            end
        endcase
    endtask

    task automatic step(input bit b, input bit r, input string tag);
        lane_bit = b;
        frame_rst_n = r;
        @(posedge clk);
        model_edge(b, r);
        @(negedge clk);
        if (roll_pulse === 1'b1) rolls++;
        check(tag, in_frame, m_st == 2, "in_frame");
        check(tag, roll_pulse, m_roll, "roll_pulse");
    endtask

    task automatic send_word(input logic [31:0] w, input string tag);
        for (int i = 31; i >= 0; i--) step(w[i], 1'b1, tag);
    endtask

    // One frame: a 32-bit head (marker or corrupted) and random fill.
    task automatic send_frame(input bit good, input string tag);
        logic [31:0] head;
        head = good ? MK : (MK ^ ($urandom() | 32'h1));
        send_word(head, tag);
        for (int i = 32; i < FB; i++) step($urandom() & 1, 1'b1, tag);
    endtask

    task automatic send_noise(input int n, input string tag);
        for (int i = 0; i < n; i++) step($urandom() & 1, 1'b1, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R2: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2");
        check("R2", in_frame, 1'b0, "reset in_frame");
        check("R2", roll_pulse, 1'b0, "reset roll_pulse");

        // R3: hunt timeout rolls on a fixed grid
        rolls = 0;
        send_noise(2 * TO + 20, "R3");
        checks++;
        if (rolls != 2) begin
            fails++;
            $display("FAIL R3 roll count: actual %0d expected 2", rolls);
        end

        // R1: a marker with one bit flipped is not a match (no lock, grid kept)
        send_word(MK ^ 32'h0001_0000, "R1");
        send_noise(FB, "R1");
        send_word(MK ^ 32'h0001_0000, "R1");
        check("R1", in_frame, 1'b0, "near-marker");

        // R4/R5: two markers one frame apart lock
        step(1'b0, 1'b0, "R2");
        send_frame(1, "R4");
        send_frame(1, "R5");
        check("R5", in_frame, 1'b1, "locked after two markers");

        // R7: an extra marker off the slot is ignored
        send_word(MK, "R7");
        send_word(MK, "R7");
        check("R7", in_frame, 1'b1, "off-slot marker");

        // R8: three misses then a hit keep lock; four misses drop it
        for (int i = 0; i < 3; i++) send_frame(0, "R8");
        send_frame(1, "R8");
        check("R8", in_frame, 1'b1, "lock kept after three misses");
        for (int i = 0; i < 3; i++) send_frame(0, "R8");
        check("R8", in_frame, 1'b1, "lock kept during misses");
        send_frame(0, "R8");
        check("R8", in_frame, 1'b0, "lock lost after four misses");

        // R6: first marker, then a miss, back to hunt with a fresh timer
        send_frame(1, "R6");
        send_frame(0, "R6");
        check("R6", in_frame, 1'b0, "verify miss");
        send_noise(TO + 10, "R6");

        // R2: frame reset while locked
        send_frame(1, "R5");
        send_frame(1, "R5");
        check("R5", in_frame, 1'b1, "relock");
        step(1'b0, 1'b0, "R2");
        check("R2", in_frame, 1'b0, "reset drops lock");

        // R9 and R8: random mix of good and bad frames
        for (int k = 0; k < 40; k++) send_frame(($urandom() % 4) != 0, "R9");
        send_noise(TO, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule